// File: doc/BRIEF.md
# Flash Block Protection Checker

This block decides, access by access, whether a request to an on-chip flash array may proceed. The array is cut into 2 KB protection blocks, and every 32 consecutive blocks form one bank; there are 16 banks. For each block the block keeps two permission bits: a read permission bit and a program permission bit. Together they put the block in one of three classes: execute-only, read-only or read/write.

A requester presents an address and one of four access kinds: instruction fetch, data read, program or erase. The block answers with a combinational allow flag and the protection class of the addressed block. When a valid request is refused, a violation pulse is raised on the following clock edge. The permission words are written through a narrow register port, one 32-bit word per bank and kind. A write can only clear permission bits. Cleared bits stay cleared until the next reset.

Top module: `fprot_guard`

## Requirements
- R1: The block index is address bits [15:11] and the bank index is address bits [19:16]. Address bits [10:0] and all bits above bit 19 have no effect on the decision.
- R2: After reset every permission bit is 1, so every block is read/write and all four access kinds are allowed.
- R3: `blk_class` reports the addressed block's class. A clear read bit gives 2'b00 (execute-only), whatever the program bit holds. A set read bit with a clear program bit gives 2'b10 (read-only). Both bits set gives 2'b11 (read/write).
- R4: An instruction fetch (`req_type` = 0) is allowed in every class.
- R5: A data read (`req_type` = 1) is allowed exactly when the block's read bit is 1.
- R6: A program (`req_type` = 2) or an erase (`req_type` = 3) is allowed only when both the read bit and the program bit are 1. An execute-only block whose program bit is still 1 is refused.
- R7: A register write with `reg_kind` = 0 targets the read word of bank `reg_bank`, and `reg_kind` = 1 targets its program word. Bit i of `reg_wdata` belongs to block i. The stored word becomes old AND data, so a 1 in the data can never set a cleared bit. The new value governs decisions from the cycle after the write edge.
- R8: A write changes only the addressed word of the addressed bank. Every other bank and the other kind keep their bits.
- R9: `viol_pulse` is 1 in the cycle after a clock edge at which `req_valid` was 1 and the access was refused. Otherwise it is 0, and this includes a refused access presented with `req_valid` = 0.
- R10: Asserting reset again returns every bit to 1, which undoes all earlier clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access request is present |
| req_addr | input | 32 | Byte address of the access |
| req_type | input | 2 | Access kind: 0 fetch, 1 data read, 2 program, 3 erase |
| reg_we | input | 1 | Permission word write strobe |
| reg_bank | input | 4 | Bank whose word is written |
| reg_kind | input | 1 | 0 selects the read word, 1 selects the program word |
| reg_wdata | input | 32 | Mask ANDed into the selected word |
| allow | output | 1 | Access permitted (combinational) |
| blk_class | output | 2 | Class of the addressed block |
| viol_pulse | output | 1 | Registered access-violation event |

## Verification
The bench sweeps every block of every bank with all four access kinds. It does this after reset, after per-bank clear patterns that produce all four bit codes, and after writes that try to set bits back to 1. The bit code with read clear and program set is the sharpest case: a design that decodes the class from the program bit first would let that block be programmed or erased. Aliased sweeps with high address bits and granule offsets set would catch a design that slices the wrong address bits, because its decisions would then land on the wrong block. The bench also checks the edge at which a write takes effect, the refused request presented with `req_valid` low that must produce no pulse, and a second reset that must undo every clear.

// File: rtl/fprot_pkg.sv
package fprot_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_DREAD = 2'd1,
        ACC_PROG  = 2'd2,
        ACC_ERASE = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CLS_EXEC = 2'b00,
        CLS_RO   = 2'b10,
        CLS_RW   = 2'b11
    } prot_class_e;

    typedef struct packed {
        logic rd_en;
        logic pg_en;
    } prot_bits_t;

    typedef struct packed {
        prot_class_e cls;
        logic        ok;
    } prot_verdict_t;

    // Read permission dominates: without it the block is execute-only.
    function automatic prot_class_e classify(prot_bits_t b);
        if (!b.rd_en)
            return CLS_EXEC;
        if (!b.pg_en)
            return CLS_RO;
        return CLS_RW;
    endfunction

    function automatic logic permits(prot_class_e c, acc_kind_e k);
        case (k)
            ACC_FETCH: return 1'b1;
            ACC_DREAD: return (c != CLS_EXEC);
            default:   return (c == CLS_RW);
        endcase
    endfunction

endpackage

// File: rtl/fprot_words.sv
module fprot_words #(
    parameter int NUM_BANKS       = 16,
    parameter int BLOCKS_PER_BANK = 32,
    localparam int BANK_W         = $clog2(NUM_BANKS),
    localparam int FLAT_W         = NUM_BANKS * BLOCKS_PER_BANK
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [BANK_W-1:0]          wr_bank,
    input  logic                       wr_kind,
    input  logic [BLOCKS_PER_BANK-1:0] wr_mask,
    output logic [FLAT_W-1:0]          rd_flat,
    output logic [FLAT_W-1:0]          pg_flat
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BLOCKS_PER_BANK-1:0] rd_q;
        logic [BLOCKS_PER_BANK-1:0] pg_q;
        logic                       hit;

        assign hit = wr_en && (wr_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q <= '1;
                pg_q <= '1;
            end else if (hit) begin
                if (wr_kind)
                    pg_q <= pg_q & wr_mask;
                else
                    rd_q <= rd_q & wr_mask;
            end
        end

        assign rd_flat[b*BLOCKS_PER_BANK +: BLOCKS_PER_BANK] = rd_q;
        assign pg_flat[b*BLOCKS_PER_BANK +: BLOCKS_PER_BANK] = pg_q;
    end

endmodule

// File: rtl/fprot_lookup.sv
module fprot_lookup
    import fprot_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int GRAN_LOG2       = 11,
    parameter int NUM_BANKS       = 16,
    parameter int BLOCKS_PER_BANK = 32,
    localparam int IDX_W          = $clog2(NUM_BANKS) + $clog2(BLOCKS_PER_BANK),
    localparam int FLAT_W         = NUM_BANKS * BLOCKS_PER_BANK
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [FLAT_W-1:0] rd_flat,
    input  logic [FLAT_W-1:0] pg_flat,
    output prot_bits_t        bits
);

    // Bank and block indices sit next to each other above the granule,
    // so together they form one linear index into the flattened words.
    logic [IDX_W-1:0] idx;

    assign idx        = addr[GRAN_LOG2 +: IDX_W];
    assign bits.rd_en = rd_flat[idx];
    assign bits.pg_en = pg_flat[idx];

endmodule

// File: rtl/fprot_policy.sv
module fprot_policy
    import fprot_pkg::*;
(
    input  prot_bits_t    bits,
    input  acc_kind_e     kind,
    output prot_verdict_t verdict
);

    always_comb begin
        verdict.cls = classify(bits);
        verdict.ok  = permits(verdict.cls, kind);
    end

endmodule

// File: rtl/fprot_guard.sv
module fprot_guard
    import fprot_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int GRAN_LOG2       = 11,
    parameter int NUM_BANKS       = 16,
    parameter int BLOCKS_PER_BANK = 32,
    localparam int BANK_W         = $clog2(NUM_BANKS),
    localparam int FLAT_W         = NUM_BANKS * BLOCKS_PER_BANK
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [1:0]                 req_type,
    input  logic                       reg_we,
    input  logic [BANK_W-1:0]          reg_bank,
    input  logic                       reg_kind,
    input  logic [BLOCKS_PER_BANK-1:0] reg_wdata,
    output logic                       allow,
    output logic [1:0]                 blk_class,
    output logic                       viol_pulse
);

    logic [FLAT_W-1:0] rd_flat;
    logic [FLAT_W-1:0] pg_flat;
    prot_bits_t        bits;
    prot_verdict_t     verdict;
    logic              viol_q;

    fprot_words #(
        .NUM_BANKS       (NUM_BANKS),
        .BLOCKS_PER_BANK (BLOCKS_PER_BANK)
    ) u_words (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_we),
        .wr_bank (reg_bank),
        .wr_kind (reg_kind),
        .wr_mask (reg_wdata),
        .rd_flat (rd_flat),
        .pg_flat (pg_flat)
    );

    fprot_lookup #(
        .ADDR_W          (ADDR_W),
        .GRAN_LOG2       (GRAN_LOG2),
        .NUM_BANKS       (NUM_BANKS),
        .BLOCKS_PER_BANK (BLOCKS_PER_BANK)
    ) u_lookup (
        .addr    (req_addr),
        .rd_flat (rd_flat),
        .pg_flat (pg_flat),
        .bits    (bits)
    );

    fprot_policy u_policy (
        .bits    (bits),
        .kind    (acc_kind_e'(req_type)),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst)
            viol_q <= 1'b0;
        else
            viol_q <= req_valid && !verdict.ok;
    end

    assign allow      = verdict.ok;
    assign blk_class  = verdict.cls;
    assign viol_pulse = viol_q;

endmodule

// File: rtl/fprot_guard_chk.sv
module fprot_guard_chk #(
    parameter int FLAT_W = 512
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_type,
    input logic              allow,
    input logic [1:0]        blk_class,
    input logic              viol_pulse,
    input logic [FLAT_W-1:0] rd_flat,
    input logic [FLAT_W-1:0] pg_flat
);

    AST_RESET_ALL_OPEN: assert property (@(posedge clk)
        rst |=> ((&rd_flat) && (&pg_flat) && !viol_pulse)); // R2

    AST_FETCH_ALWAYS: assert property (@(posedge clk) disable iff (rst)
        (req_type == 2'd0) |-> allow); // R4

    AST_EXEC_NO_DREAD: assert property (@(posedge clk) disable iff (rst)
        (req_type == 2'd1 && blk_class == 2'b00) |-> !allow); // R5

    AST_WRITE_NEEDS_RW: assert property (@(posedge clk) disable iff (rst)
        (req_type[1] && allow) |-> (blk_class == 2'b11)); // R6

    AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (blk_class != 2'b01)); // R3

    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (((rd_flat & ~$past(rd_flat)) == '0) &&
                  ((pg_flat & ~$past(pg_flat)) == '0))); // R7

    AST_VIOL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !allow) |=> viol_pulse); // R9

    AST_NO_SPURIOUS_VIOL: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !allow) |=> !viol_pulse); // R9

endmodule

bind fprot_guard fprot_guard_chk #(.FLAT_W(FLAT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_type   (req_type),
    .allow      (allow),
    .blk_class  (blk_class),
    .viol_pulse (viol_pulse),
    .rd_flat    (rd_flat),
    .pg_flat    (pg_flat)
);

// File: tb/tb_fprot_guard.sv
`timescale 1ns/1ps
module tb_fprot_guard;

    localparam int NB = 16;
    localparam int NK = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_type = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_bank = '0;
    logic        reg_kind = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        allow;
    logic [1:0]  blk_class;
    logic        viol_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rd_m [NB];
    logic [31:0] pg_m [NB];

    always #4 clk = ~clk;

    fprot_guard dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_type(req_type), .reg_we(reg_we), .reg_bank(reg_bank),
        .reg_kind(reg_kind), .reg_wdata(reg_wdata), .allow(allow),
        .blk_class(blk_class), .viol_pulse(viol_pulse)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            rd_m[b] = '1;
            pg_m[b] = '1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic wr(input int bank, input logic kind, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_bank = 4'(bank); reg_kind = kind; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
        if (kind) pg_m[bank] = pg_m[bank] & data;
        else      rd_m[bank] = rd_m[bank] & data;
    endtask

    // One access; expectations follow R3..R6 and R9 arithmetically.
    task automatic access(input int bank, input int blk, input int kind,
                          input logic vld, input logic [31:0] hi, input string tag);
        int  code, ecls;
        logic eallow, r, p;
        r = rd_m[bank][blk];
        p = pg_m[bank][blk];
        code = int'(r) * 2 + int'(p);
        ecls = (code == 1) ? 0 : code;
        eallow = (kind == 0) || (kind == 1 && r) || (kind >= 2 && code == 3);
        @(negedge clk);
        req_valid = vld;
        req_type  = 2'(kind);
        req_addr  = hi | 32'((bank * NK + blk) * 2048) | 32'((blk * 97 + kind * 389) % 2048);
        #1;
        check(blk_class == 2'(ecls), {tag, " R3 class"}, int'(blk_class), ecls);
        if (kind == 0)      check(allow == eallow, {tag, " R4 fetch"}, int'(allow), int'(eallow));
        else if (kind == 1) check(allow == eallow, {tag, " R5 dread"}, int'(allow), int'(eallow));
        else                check(allow == eallow, {tag, " R6 prog/erase"}, int'(allow), int'(eallow));
        @(posedge clk);
        #2;
        check(viol_pulse == (vld && !eallow), {tag, " R9 viol"}, int'(viol_pulse), int'(vld && !eallow));
    endtask

    task automatic sweep(input logic [31:0] hi, input string tag);
        for (int b = 0; b < NB; b++)
            for (int k = 0; k < NK; k++)
                for (int t = 0; t < 4; t++)
                    access(b, k, t, 1'b1, hi, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(viol_pulse == 1'b0, "R2 reset viol", int'(viol_pulse), 0);
        sweep(32'h0, "R2 reset");

        // R8: clear one word only, the rest must stay open.
        wr(5, 1'b0, 32'hFFFF_0FFF);
        sweep(32'h0, "R8 single word");

        // Per-bank patterns that produce all four bit codes.
        for (int b = 0; b < NB; b++) begin
            wr(b, 1'b0, 32'hA5A5_5A5A ^ (32'(b) * 32'h1111_1111));
            wr(b, 1'b1, 32'h3C3C_C3C3 ^ (32'(b) * 32'h0101_0101));
        end
        sweep(32'h0, "R7 cleared");

        // R7: attempts to set bits back must be ignored.
        for (int b = 0; b < NB; b++) begin
            wr(b, 1'b0, 32'hFFFF_FFFF);
            wr(b, 1'b1, 32'hFFFF_FFFF);
        end
        sweep(32'h0, "R7 no reopen");

        // R1: high address bits alias onto the same blocks.
        sweep(32'hABC0_0000, "R1 alias");

        // R7: write takes effect from the cycle after its edge.
        rd_m[9][7] = 1'b1; pg_m[9][7] = 1'b1;
        do_reset();
        @(negedge clk);
        reg_we = 1'b1; reg_bank = 4'd9; reg_kind = 1'b1; reg_wdata = ~(32'h1 << 7);
        req_valid = 1'b0; req_type = 2'd2; req_addr = 32'((9 * NK + 7) * 2048);
        #1;
        check(allow == 1'b1, "R7 before edge", int'(allow), 1);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        check(allow == 1'b0, "R7 after edge", int'(allow), 0);
        check(blk_class == 2'b10, "R3 read-only", int'(blk_class), 2);
        pg_m[9] = ~(32'h1 << 7);

        // R9: refused request without valid makes no pulse.
        access(9, 7, 3, 1'b0, 32'h0, "R9 invalid");
        access(9, 7, 3, 1'b1, 32'h0, "R9 valid");

        // R6: read clear, program set -> execute-only, no program.
        wr(2, 1'b0, ~(32'h1 << 31));
        for (int t = 0; t < 4; t++) access(2, 31, t, 1'b1, 32'h0, "R6 code1");

        // R10: reset reopens everything.
        do_reset();
        sweep(32'h0, "R10 re-reset");

        @(negedge clk);
        req_valid = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule